// File: doc/BRIEF.md
# Two-Stage Fractional Baud Generator

This block supplies the bit-rate timing for a serial transmitter and receiver. The clock can first pass through an optional divide-by-eight prescaler. A programmable clock divider then turns the selected clock into a one-cycle sample tick. A second, 8-bit divider counts sample ticks and raises a bit tick on every (BDIV+1)-th one. The resulting bit rate is the selected clock divided by CD x (BDIV+1), which gives software fine-grained control over the rate without a single wide divide counter.

Both divider values are held in the block and loaded through a shared write-data bus with one write strobe each. A write to either divider restarts the whole cascade, so the first tick comes one full programmed period after the write. A separate restart input does the same without changing the programmed values. The block does not search for divisor values and does no serial framing.

Top module: `baudtick_gen`

## Requirements
- R1: After reset, the clock divider holds 0 and the bit divider holds 15. Neither `sample_tick` nor `bit_tick` pulses until a non-zero clock divider is written.
- R2: With `prescale_sel` = 0 and CD >= 1, `sample_tick` is a single-cycle pulse in every clock cycle k (cycle 0 is the first cycle after the restarting edge) for which (k+1) is a multiple of CD.
- R3: With `prescale_sel` = 1, the clock is first divided by 8, so `sample_tick` pulses only in cycles k for which (k+1) is a multiple of 8 x CD. It is never high in two consecutive cycles.
- R4: A CD value of 1 is a bypass: one sample tick for every selected clock, which is every cycle when unprescaled and every eighth cycle when prescaled.
- R5: A CD value of 0 stops `sample_tick` and `bit_tick` completely.
- R6: `bit_tick` pulses only together with `sample_tick`, on every (BDIV+1)-th sample tick counted from the last restart. Every 8-bit BDIV value is honoured, and BDIV = 0 gives a bit tick on every sample tick.
- R7: `cd_wr` loads `wr_data[15:0]` as CD and `bdiv_wr` loads `wr_data[7:0]` as BDIV. Either write restarts the prescaler and both counters, so the new timing runs from cycle 0 after the write edge.
- R8: `restart` clears the prescaler and both counters and keeps the programmed values. In any cycle where `restart`, `cd_wr` or `bdiv_wr` is high, both tick outputs are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale_sel | input | 1 | 1 = divide the clock by 8 ahead of the clock divider |
| wr_data | input | 16 | Write data for the divider registers |
| cd_wr | input | 1 | Load wr_data as the clock divider and restart |
| bdiv_wr | input | 1 | Load wr_data[7:0] as the bit divider and restart |
| restart | input | 1 | Restart all counters, keeping the divider values |
| sample_tick | output | 1 | One-cycle pulse once per sample period |
| bit_tick | output | 1 | One-cycle pulse once per bit period |

## Verification
On every cycle the assertions check these properties: a bit tick never appears without a sample tick, a zero clock divider keeps the outputs silent, the counters stay inside their programmed bounds, prescaled ticks are never adjacent, and any cycle that restarts the cascade is quiet. Only the bench scenarios can show that the pulses fall in exactly the right cycles. They compare each cycle against a closed-form period formula across random divider settings, the bypass and stop values, the largest clock divider, and restarts that land on a tick.

// File: rtl/baudtick_pkg.sv
package baudtick_pkg;

  // True when a modulo counter sits on its final count for a given limit.
  // A zero limit never produces a hit.
  function automatic logic last_count16(input logic [15:0] cnt,
                                        input logic [15:0] limit);
    return (limit != 16'd0) && (cnt == limit - 16'd1);
  endfunction

  // Next value of a wrapping counter that counts 0..limit-1.
  function automatic logic [15:0] wrap_next16(input logic [15:0] cnt,
                                              input logic [15:0] limit);
    if (limit == 16'd0 || cnt >= limit - 16'd1)
      return 16'd0;
    return cnt + 16'd1;
  endfunction

  // Next value of a counter that counts 0..top inclusive.
  function automatic logic [7:0] wrap_incl8(input logic [7:0] cnt,
                                            input logic [7:0] top);
    if (cnt >= top)
      return 8'd0;
    return cnt + 8'd1;
  endfunction

endpackage

// File: rtl/bg_div_regs.sv
module bg_div_regs #(
  parameter int CD_W       = 16,
  parameter int BDIV_W     = 8,
  parameter int BDIV_RESET = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CD_W-1:0]   wr_data,
  input  logic              cd_wr,
  input  logic              bdiv_wr,
  output logic [CD_W-1:0]   cd_q,
  output logic [BDIV_W-1:0] bdiv_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_q   <= '0;
      bdiv_q <= BDIV_W'(BDIV_RESET);
    end else begin
      if (cd_wr)   cd_q   <= wr_data;
      if (bdiv_wr) bdiv_q <= wr_data[BDIV_W-1:0];
    end
  end

endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
  parameter int PRE_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sel,
  output logic pre_en
);

  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  generate
    if (PRE_DIV > 1) begin : g_div
      logic [PRE_W-1:0] pre_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          pre_cnt <= '0;
        else if (clr || !sel)
          pre_cnt <= '0;
        else if (pre_cnt == PRE_W'(PRE_DIV - 1))
          pre_cnt <= '0;
        else
          pre_cnt <= pre_cnt + 1'b1;
      end

      assign pre_en = sel ? (pre_cnt == PRE_W'(PRE_DIV - 1)) : 1'b1;
    end else begin : g_pass
      logic unused_ok;
      assign unused_ok = clr ^ sel ^ clk ^ rst_n;
      assign pre_en    = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/bg_sample_div.sv
module bg_sample_div #(
  parameter int CD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [CD_W-1:0] cd,
  output logic [CD_W-1:0] s_cnt,
  output logic            sample_ev
);
  import baudtick_pkg::*;

  logic [15:0] cnt_ext;
  logic [15:0] cd_ext;

  assign cnt_ext = 16'(s_cnt);
  assign cd_ext  = 16'(cd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      s_cnt <= '0;
    else if (clr)
      s_cnt <= '0;
    else if (en)
      s_cnt <= CD_W'(wrap_next16(cnt_ext, cd_ext));
  end

  assign sample_ev = en && last_count16(cnt_ext, cd_ext);

endmodule

// File: rtl/bg_bit_div.sv
module bg_bit_div #(
  parameter int BDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [BDIV_W-1:0] bdiv,
  output logic [BDIV_W-1:0] b_cnt,
  output logic              bit_ev
);
  import baudtick_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      b_cnt <= '0;
    else if (clr)
      b_cnt <= '0;
    else if (adv)
      b_cnt <= BDIV_W'(wrap_incl8(8'(b_cnt), 8'(bdiv)));
  end

  assign bit_ev = (b_cnt == bdiv);

endmodule

// File: rtl/baudtick_gen.sv
module baudtick_gen #(
  parameter int CD_W       = 16,
  parameter int BDIV_W     = 8,
  parameter int PRE_DIV    = 8,
  parameter int BDIV_RESET = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prescale_sel,
  input  logic [CD_W-1:0] wr_data,
  input  logic            cd_wr,
  input  logic            bdiv_wr,
  input  logic            restart,
  output logic            sample_tick,
  output logic            bit_tick
);

  logic [CD_W-1:0]   cd_q;
  logic [BDIV_W-1:0] bdiv_q;
  logic [CD_W-1:0]   s_cnt;
  logic [BDIV_W-1:0] b_cnt;
  logic              restart_any;
  logic              pre_en;
  logic              sample_ev;
  logic              bit_ev;

  assign restart_any = restart | cd_wr | bdiv_wr;

  bg_div_regs #(.CD_W(CD_W), .BDIV_W(BDIV_W), .BDIV_RESET(BDIV_RESET)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_data (wr_data),
    .cd_wr   (cd_wr),
    .bdiv_wr (bdiv_wr),
    .cd_q    (cd_q),
    .bdiv_q  (bdiv_q)
  );

  bg_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (restart_any),
    .sel    (prescale_sel),
    .pre_en (pre_en)
  );

  bg_sample_div #(.CD_W(CD_W)) u_sdiv (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (restart_any),
    .en        (pre_en),
    .cd        (cd_q),
    .s_cnt     (s_cnt),
    .sample_ev (sample_ev)
  );

  assign sample_tick = sample_ev & ~restart_any;

  bg_bit_div #(.BDIV_W(BDIV_W)) u_bdiv (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (restart_any),
    .adv    (sample_tick),
    .bdiv   (bdiv_q),
    .b_cnt  (b_cnt),
    .bit_ev (bit_ev)
  );

  assign bit_tick = sample_tick & bit_ev;

endmodule

// File: rtl/baudtick_gen_chk.sv
module baudtick_gen_chk #(
  parameter int CD_W   = 16,
  parameter int BDIV_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prescale_sel,
  input logic              restart_any,
  input logic [CD_W-1:0]   cd_q,
  input logic [BDIV_W-1:0] bdiv_q,
  input logic [CD_W-1:0]   s_cnt,
  input logic [BDIV_W-1:0] b_cnt,
  input logic              sample_tick,
  input logic              bit_tick
);

  p_bit_with_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  p_bit_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b_cnt <= bdiv_q);

  p_cd_zero_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_q == '0) |-> (!sample_tick && !bit_tick && s_cnt == '0));

  p_sample_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_q != '0) |-> (s_cnt < cd_q));

  p_prescaled_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prescale_sel && sample_tick) |=> (!prescale_sel || !sample_tick));

  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_any |-> (!sample_tick && !bit_tick));

  p_restart_full_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_any |=> (cd_q < CD_W'(2) || !sample_tick));

endmodule

bind baudtick_gen baudtick_gen_chk #(.CD_W(CD_W), .BDIV_W(BDIV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .prescale_sel (prescale_sel),
  .restart_any  (restart_any),
  .cd_q         (cd_q),
  .bdiv_q       (bdiv_q),
  .s_cnt        (s_cnt),
  .b_cnt        (b_cnt),
  .sample_tick  (sample_tick),
  .bit_tick     (bit_tick)
);

// File: tb/baudtick_gen_test.sv
module baudtick_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prescale_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        cd_wr = 1'b0;
  logic        bdiv_wr = 1'b0;
  logic        restart = 1'b0;
  logic        sample_tick;
  logic        bit_tick;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // bench model state
  int    k = 0;
  int    m_cd = 0;
  int    m_bdiv = 15;
  bit    m_sel = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  baudtick_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .prescale_sel (prescale_sel),
    .wr_data      (wr_data),
    .cd_wr        (cd_wr),
    .bdiv_wr      (bdiv_wr),
    .restart      (restart),
    .sample_tick  (sample_tick),
    .bit_tick     (bit_tick)
  );

  function automatic bit want_sample(int kk, int cd, bit sel);
    int p = sel ? 8 : 1;
    if (cd == 0) return 1'b0;
    return ((kk + 1) % (p * cd)) == 0;
  endfunction

  function automatic bit want_bit(int kk, int cd, bit sel, int bd);
    int p = sel ? 8 : 1;
    if (!want_sample(kk, cd, sel)) return 1'b0;
    return (((kk + 1) / (p * cd)) % (bd + 1)) == 0;
  endfunction

  // At a falling edge with inputs set: compare, then advance model over the rising edge.
  task automatic step();
    bit rs;
    bit es, eb;
    #1;
    rs = restart || cd_wr || bdiv_wr;
    es = rs ? 1'b0 : want_sample(k, m_cd, m_sel);
    eb = rs ? 1'b0 : want_bit(k, m_cd, m_sel, m_bdiv);
    compared++;
    if (sample_tick !== es || bit_tick !== eb) begin
      mismatched++;
      $display("FAIL %s k=%0d cd=%0d bdiv=%0d sel=%0d: sample/bit actual %b%b expected %b%b",
               rs ? "R8" : tag, k, m_cd, m_bdiv, m_sel, sample_tick, bit_tick, es, eb);
    end
    @(posedge clk);
    if (rs) begin
      k = 0;
      if (cd_wr)   m_cd   = int'(wr_data);
      if (bdiv_wr) m_bdiv = int'(wr_data[7:0]);
    end else begin
      k++;
    end
    m_sel = prescale_sel;
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_cd(int v);
    wr_data = 16'(v); cd_wr = 1'b1; step(); cd_wr = 1'b0;
  endtask

  task automatic write_bdiv(int v);
    wr_data = 16'(v); bdiv_wr = 1'b1; step(); bdiv_wr = 1'b0;
  endtask

  task automatic do_restart(bit sel);
    prescale_sel = sel; restart = 1'b1; step(); restart = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset and after it, CD resets to 0
    compared++;
    if (sample_tick !== 1'b0 || bit_tick !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 in reset: actual %b%b expected 00", sample_tick, bit_tick);
    end
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; run(40);

    // R2: plain division, bdiv from reset value 15
    tag = "R2"; write_cd(5); run(120);
    // R6: BDIV = 0 and BDIV = 4
    tag = "R6"; write_bdiv(0); run(30);
    write_bdiv(4); run(80);
    // R4: bypass unprescaled and prescaled
    tag = "R4"; write_cd(1); run(30);
    do_restart(1'b1); run(100);
    // R3: prescaled division
    tag = "R3"; write_cd(3); run(260);
    // R5: stop value
    tag = "R5"; write_cd(0); run(80);
    // R8: restart landing exactly on a tick cycle
    tag = "R8"; do_restart(1'b0); write_cd(6); run(5);
    do_restart(1'b0); run(20);
    run(2); do_restart(1'b0); run(30);
    // R7: largest CD, first tick one full period after the write
    tag = "R7"; write_bdiv(0); write_cd(65535); run(65540);
    write_bdiv(255); write_cd(2); run(1100);

    // R2/R3/R6 random configurations with fixed seed
    void'($urandom(32'd20240611));
    for (int t = 0; t < 40; t++) begin
      bit s = 1'($urandom_range(0, 1));
      tag = s ? "R3" : "R2";
      do_restart(s);
      write_cd(int'($urandom_range(1, 12)));
      write_bdiv(int'($urandom_range(0, 9)));
      tag = "R6";
      run(int'($urandom_range(150, 500)));
      if ($urandom_range(0, 3) == 0) begin
        tag = "R8"; do_restart(s); run(100);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule